// File: doc/BRIEF.md
# Peak-Hold Cell Derandomizer Sequencer

This sequencer manages a bank of analog peak-hold cells that sit between randomly timed detector pulses and a converter running at a steady pace. At all times one free cell has its input switch closed and waits for the next pulse. When the analog side reports that a peak was found, the block retires that cell into an ordered queue of held samples and closes the input switch of another free cell. Capture can therefore continue while the converter reads earlier samples.

The host reads through a simple request/consume handshake. A read request moves the oldest held cell onto the output: its output switch closes, its index appears on `rd_cell`, and `data_valid` goes high. That cell stays on the output until the host sends a done request after conversion. The done request clears the cell and returns it to the free pool. There is only one output slot, so this handshake is the back-pressure. A read request is refused while a sample is still on the output or while the queue is empty. When every cell is held, `full` is high, no input switch is closed, and further peak-found pulses are dropped and counted.

Top module: `derand_seq`

## Requirements
- R1: After reset, only cell 0's input switch is closed (`in_sw` bit 0, one bit per cell, bit i for cell i). `out_sw` is zero, `empty` is 1, `full` is 0, `data_valid` is 0 and `lost_cnt` is 0.
- R2: While at least one cell is free, exactly one bit of `in_sw` is set. No cell ever has its input and output switches closed together.
- R3: A `peak_found` pulse with a cell armed appends that cell's index to the read queue. From the next cycle, `empty` is 0 and `in_sw` selects the lowest-index free cell other than the one just captured.
- R4: A read request with a non-empty queue and no cell on the output takes the oldest queued index. From the next cycle that index is on `rd_cell`, its `out_sw` bit is set and `data_valid` is 1. Cells come out in capture order.
- R5: A done request while a cell is on the output clears `out_sw` and `data_valid` from the next cycle and frees the cell. If no cell was armed, the freed cell becomes the armed one.
- R6: With no readout, the block accepts up to N captures. After N captures, `full` is 1 and `in_sw` is zero.
- R7: A `peak_found` pulse while `full` is 1 is dropped and leaves the queue unchanged. It raises `lost_cnt` by one, and `lost_cnt` saturates at its all-ones value.
- R8: A read request while the queue is empty, or while a cell is on the output, is ignored. `rd_cell`, `out_sw` and `data_valid` keep their values.
- R9: A done request while no cell is on the output has no effect on any output.
- R10: Captures into free cells proceed while a cell is on the output.
- R11: The armed cell stays armed until it captures. Freeing a lower-index cell does not move `in_sw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| peak_found | input | 1 | One-cycle pulse: the armed cell holds a peak |
| rd_req | input | 1 | Request to put the oldest held cell on the output |
| done_req | input | 1 | Conversion finished; free the cell on the output |
| in_sw | output | N_CELLS | Input switch enables, one-hot or zero |
| out_sw | output | N_CELLS | Output switch enables, one-hot or zero |
| rd_cell | output | $clog2(N_CELLS) | Index of the cell on the output |
| data_valid | output | 1 | A cell is on the output |
| full | output | 1 | Every cell is held; no cell armed |
| empty | output | 1 | Read queue holds no index |
| lost_cnt | output | LOST_W | Saturating count of dropped peaks |

## Verification
Captures are run in several patterns:
- Back-to-back captures from reset check the lowest-free arming order and the fill to full.
- Captures interleaved with a readout show that the output slot and the arming path work independently.
- Freeing a low cell while a higher one is armed separates "keep the armed cell" from "re-pick the lowest free cell".
- Releasing a cell while full checks the re-arm path, and a burst of peaks while full drives the lost counter into saturation.
- Reads and done requests at the wrong moments (empty queue, busy output, idle output) show that the handshake refuses them.
- A scoreboard compares every sample that appears on the output against the expected capture order, including the wrapped order produced after cells are recycled.

// File: rtl/derand_pkg.sv
package derand_pkg;

  localparam int MAX_CELLS = 32;

  // index of the lowest set bit; 0 when none is set
  function automatic int unsigned lowest_set(input logic [MAX_CELLS-1:0] v);
    int unsigned r;
    logic hit;
    r = 0;
    hit = 1'b0;
    for (int i = 0; i < MAX_CELLS; i++) begin
      if (v[i] && !hit) begin
        r = i;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/derand_alloc.sv
module derand_alloc
  import derand_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int LOST_W  = 8,
  localparam int IW = $clog2(N_CELLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              rel,
  input  logic [IW-1:0]     rel_idx,
  output logic              cap_ok,
  output logic              arm_vld,
  output logic [IW-1:0]     arm_idx,
  output logic [LOST_W-1:0] lost_cnt
);

  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  logic [N_CELLS-1:0] free_q, free_nx;
  logic               vld_nx;
  logic [IW-1:0]      idx_nx;

  assign cap_ok = cap && arm_vld;

  always_comb begin
    free_nx = free_q;
    if (cap_ok) free_nx[arm_idx] = 1'b0;
    if (rel)    free_nx[rel_idx] = 1'b1;
    vld_nx = arm_vld;
    idx_nx = arm_idx;
    if (cap_ok) begin
      vld_nx = |free_nx;
      idx_nx = IW'(lowest_set(MAX_CELLS'(free_nx)));
    end else if (!arm_vld && rel) begin
      vld_nx = 1'b1;
      idx_nx = rel_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q   <= '1;
      arm_vld  <= 1'b1;
      arm_idx  <= '0;
      lost_cnt <= '0;
    end else begin
      free_q  <= free_nx;
      arm_vld <= vld_nx;
      arm_idx <= idx_nx;
      if (cap && !arm_vld && lost_cnt != LOST_MAX) lost_cnt <= lost_cnt + 1'b1;
    end
  end

  AST_ARM_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    arm_vld |-> free_q[arm_idx]); // R2
  AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    arm_vld && !cap |=> arm_vld && $stable(arm_idx)); // R11
  AST_LOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap && !arm_vld) |=> $stable(lost_cnt)); // R7

endmodule

// File: rtl/derand_fifo.sv
module derand_fifo #(
  parameter int N_CELLS = 8,
  localparam int IW = $clog2(N_CELLS),
  localparam int CW = $clog2(N_CELLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic [IW-1:0] head,
  output logic          q_empty
);

  localparam logic [IW-1:0] LAST = IW'(N_CELLS - 1);

  logic [IW-1:0] slots [N_CELLS];
  logic [IW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign head    = slots[rp];
  assign q_empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        slots[wp] <= push_idx;
        wp <= (wp == LAST) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> cnt < CW'(N_CELLS)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt != '0); // R8

endmodule

// File: rtl/derand_rdslot.sv
module derand_rdslot #(
  parameter int N_CELLS = 8,
  localparam int IW = $clog2(N_CELLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic               done_req,
  input  logic               q_empty,
  input  logic [IW-1:0]      head,
  output logic               pop,
  output logic               busy,
  output logic [IW-1:0]      cell_q,
  output logic               rel,
  output logic [N_CELLS-1:0] out_sw
);

  assign pop = rd_req && !busy && !q_empty;
  assign rel = done_req && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cell_q <= '0;
    end else if (pop) begin
      busy   <= 1'b1;
      cell_q <= head;
    end else if (rel) begin
      busy <= 1'b0;
    end
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_osw
    assign out_sw[i] = busy && (cell_q == IW'(i));
  end

  AST_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done_req |=> busy && $stable(cell_q)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (!rd_req || q_empty) |=> !busy); // R9

endmodule

// File: rtl/derand_seq.sv
module derand_seq #(
  parameter int N_CELLS = 8,
  parameter int LOST_W  = 8,
  localparam int IW = $clog2(N_CELLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               peak_found,
  input  logic               rd_req,
  input  logic               done_req,
  output logic [N_CELLS-1:0] in_sw,
  output logic [N_CELLS-1:0] out_sw,
  output logic [IW-1:0]      rd_cell,
  output logic               data_valid,
  output logic               full,
  output logic               empty,
  output logic [LOST_W-1:0]  lost_cnt
);

  logic          cap_ok, arm_vld, pop, busy, rel;
  logic [IW-1:0] arm_idx, head, cell_q;

  derand_alloc #(.N_CELLS(N_CELLS), .LOST_W(LOST_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .cap(peak_found), .rel(rel), .rel_idx(cell_q),
    .cap_ok(cap_ok), .arm_vld(arm_vld), .arm_idx(arm_idx), .lost_cnt(lost_cnt)
  );

  derand_fifo #(.N_CELLS(N_CELLS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(cap_ok), .push_idx(arm_idx), .pop(pop),
    .head(head), .q_empty(empty)
  );

  derand_rdslot #(.N_CELLS(N_CELLS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .done_req(done_req),
    .q_empty(empty), .head(head), .pop(pop), .busy(busy), .cell_q(cell_q),
    .rel(rel), .out_sw(out_sw)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_isw
    assign in_sw[i] = arm_vld && (arm_idx == IW'(i));
  end

  assign full       = !arm_vld;
  assign data_valid = busy;
  assign rd_cell    = cell_q;

  AST_SW_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sw & out_sw) == '0); // R2
  AST_ONE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_sw)); // R2
  AST_CAPTURE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    peak_found && !full |=> !empty); // R3
  AST_READ_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !data_valid && !empty |=> data_valid && $countones(out_sw) == 1); // R4

endmodule

// File: tb/test_derand_seq.sv
module test_derand_seq;

  localparam int N  = 4;
  localparam int LW = 3;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic peak_found = 1'b0, rd_req = 1'b0, done_req = 1'b0;
  logic [N-1:0]  in_sw, out_sw;
  logic [1:0]    rd_cell;
  logic          data_valid, full, empty;
  logic [LW-1:0] lost_cnt;

  always #10 clk = ~clk;

  derand_seq #(.N_CELLS(N), .LOST_W(LW)) i_derand_seq (
    .clk(clk), .rst_n(rst_n), .peak_found(peak_found), .rd_req(rd_req),
    .done_req(done_req), .in_sw(in_sw), .out_sw(out_sw), .rd_cell(rd_cell),
    .data_valid(data_valid), .full(full), .empty(empty), .lost_cnt(lost_cnt)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model built from the requirements
  int  arm = 0;
  bit  fr [N];
  int  mq [$];
  int  sbq [$];
  bit  busy = 0;
  int  cur = 0;
  int  lost = 0;

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lowest();
    for (int i = 0; i < N; i++) if (fr[i]) return i;
    return -1;
  endfunction

  task automatic check_state(string req);
    check(req, "in_sw", in_sw, (arm < 0) ? 0 : (1 << arm));
    check(req, "out_sw", out_sw, busy ? (1 << cur) : 0);
    check(req, "full", full, arm < 0);
    check(req, "empty", empty, mq.size() == 0);
    check(req, "data_valid", data_valid, busy);
    check(req, "lost_cnt", lost_cnt, lost);
  endtask

  // driver tasks: stimulus plus expected items into the scoreboard
  task automatic capture();
    @(negedge clk) peak_found = 1'b1;
    @(negedge clk) peak_found = 1'b0;
    if (arm >= 0) begin
      mq.push_back(arm);
      sbq.push_back(arm);
      fr[arm] = 0;
      arm = lowest();
    end else if (lost < LMAX) lost++;
  endtask

  task automatic read();
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    if (!busy && mq.size() > 0) begin
      cur = mq.pop_front();
      busy = 1;
    end
  endtask

  task automatic done();
    @(negedge clk) done_req = 1'b1;
    @(negedge clk) done_req = 1'b0;
    if (busy) begin
      fr[cur] = 1;
      busy = 0;
      if (arm < 0) arm = cur;
    end
  endtask

  // monitor: each new output sample must be the oldest expected capture
  logic dv_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (data_valid && !dv_d) begin
        if (sbq.size() == 0) check("R4", "unexpected sample", rd_cell, -1);
        else check("R4", "rd_cell order", rd_cell, sbq.pop_front());
      end
      dv_d = data_valid;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) fr[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    read();  check_state("R8 read while empty");
    done();  check_state("R9 done while idle");

    capture(); check_state("R3");
    capture(); check_state("R3");
    check("R3", "in_sw after two", in_sw, 4);

    read();  check_state("R4");
    read();  check_state("R8 read while busy");
    check("R8", "rd_cell held", rd_cell, 0);

    capture(); check_state("R10 capture during readout");
    done();    check_state("R11 arm kept after low free");
    check("R11", "in_sw stays", in_sw, 8);

    capture(); check_state("R3 wrap to lowest");
    capture(); check_state("R6 full");
    check("R6", "full after N", full, 1);

    for (int k = 0; k < 9; k++) begin
      capture();
      check_state("R7");
    end
    check("R7", "lost saturated", lost_cnt, LMAX);

    read(); check_state("R4");
    done(); check_state("R5 re-arm released");
    check("R5", "in_sw rearm", in_sw, 2);
    for (int k = 0; k < 3; k++) begin
      read(); check_state("R4");
      done(); check_state("R5");
    end
    check("R5", "empty after drain", empty, 1);

    for (int k = 0; k < N; k++) begin
      capture();
      check_state("R6");
    end
    read(); capture(); check_state("R7 drop while busy full");
    for (int k = 0; k < N; k++) begin
      done(); check_state("R5");
      read(); check_state("R4");
    end
    done(); check_state("R9");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule